// File: doc/BRIEF.md
# Load/Store Alignment Exception Detector

This block sits beside a load/store unit and looks at every memory access it issues. From the access class, the effective address, the access size, the page attributes, the translation flag and the little-endian mode bit, it decides whether the access must trap with an alignment exception. When an access traps, the block also latches the faulting data address so that a handler can read it.

The access is presented for one cycle with `acc_valid`. One cycle later, `exc_req` and `exc_cause` report the verdict, and `fault_addr` holds the captured address. Only one cause is ever reported. When several conditions hold at once, a fixed priority picks the cause.

A two-state machine sequences the report:
- `S_CLEAR`: no request is pending. It moves to `S_TRAP` when a valid access faults, and otherwise stays in `S_CLEAR`.
- `S_TRAP`: `exc_req` is high for this cycle. It stays in `S_TRAP` when the next valid access also faults, and otherwise returns to `S_CLEAR`.

Top module: `align_exc_detector`

## Requirements
- R1: A floating-point access (class 1) whose address has `ea[1:0]` not equal to 0 traps with cause 3 (word-class misalignment).
- R2: A cache-block-zero access (class 2) traps with cause 2 when `xlate_on` is 1 and either `pg_wt` or `pg_ci` is 1, whatever the address bits. With translation off, or with neither attribute set, the page attributes do not make it trap.
- R3: A load/store multiple (class 3), a load-reserved (class 4) or a store-conditional (class 5) access traps with cause 3 when `ea[1:0]` is not 0.
- R4: While `le_mode` is 1, any access of any class whose address is not a multiple of its size traps with cause 4. The size code `acc_size` gives 1, 2, 4 or 8 bytes for codes 0 to 3. A one-byte access is never misaligned. Ordinary integer accesses (class 0, or the unused codes 6 and 7) never trap while `le_mode` is 0.
- R5: A load/store multiple while `le_mode` is 1 traps with cause 1, even when its address is aligned.
- R6: When several conditions hold at once, the cause is chosen by this priority, highest first: 1 (little-endian multiple), 2 (cache-block-zero page attribute), 3 (word-class misalignment), 4 (little-endian misalignment).
- R7: On a trap raised by a load/store multiple, `fault_addr` takes `acc_ea + 4`, wrapping modulo 2^ADDR_W. On any other trap, `fault_addr` takes `acc_ea` unchanged.
- R8: `fault_addr` changes only in the cycle that `exc_req` is reported high. At all other times it holds its value.
- R9: `exc_req` is high in the cycle after a faulting valid access and low otherwise. `exc_cause` is 0 whenever `exc_req` is low.
- R10: After reset, `exc_req` is 0, `exc_cause` is 0 and `fault_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_class | input | 3 | Access class: 0 integer, 1 floating-point, 2 cache-block-zero, 3 load/store multiple, 4 load-reserved, 5 store-conditional |
| acc_size | input | 2 | Log2 of the access size in bytes |
| acc_ea | input | ADDR_W | Effective address |
| pg_wt | input | 1 | Page is write-through |
| pg_ci | input | 1 | Page is caching-inhibited |
| xlate_on | input | 1 | Address translation is enabled |
| le_mode | input | 1 | Little-endian mode |
| exc_req | output | 1 | Alignment exception request |
| exc_cause | output | 3 | Cause code: 0 none, 1 to 4 as in R6 |
| fault_addr | output | ADDR_W | Captured faulting data address |

## Verification
The bench sweeps every class, size, low address pattern and mode bit combination. This exposes the following faults:
- A wrong priority shows up as a wrong cause wherever conditions overlap, for example a misaligned multiple in little-endian mode.
- A missing +4 adjustment, or one applied to the wrong class, shows up as a wrong `fault_addr`.
- A cache-block-zero check that looks at address bits, or ignores the translation flag, traps where it should not.
- A capture register that loads on every valid access is caught by the idle and non-faulting cycles, where the held address is compared with the last faulting one.
- Addresses near the top of the address space check that the +4 wraps.

// File: rtl/align_pkg.sv
package align_pkg;

    typedef enum logic [2:0] {
        CLS_INT   = 3'd0,
        CLS_FP    = 3'd1,
        CLS_BZERO = 3'd2,
        CLS_MULTI = 3'd3,
        CLS_RSV   = 3'd4,
        CLS_COND  = 3'd5
    } acc_class_e;

    typedef enum logic [2:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_LE_MULTI = 3'd1,
        CAUSE_PAGE     = 3'd2,
        CAUSE_WORD     = 3'd3,
        CAUSE_LE_MIS   = 3'd4
    } cause_e;

    typedef struct packed {
        logic le_multi;
        logic page;
        logic word;
        logic le_mis;
        logic is_multi;
    } cond_t;

endpackage

// File: rtl/align_classify.sv
module align_classify
    import align_pkg::*;
#(
    parameter int LOW_BITS = 3
) (
    input  logic [2:0]          cls,
    input  logic [1:0]          size_log2,
    input  logic [LOW_BITS-1:0] ea_low,
    input  logic                wt,
    input  logic                ci,
    input  logic                xlate,
    input  logic                le,
    output cond_t               cond
);
    logic [LOW_BITS-1:0] size_mask;
    logic                word_class;

    // Build the mask of the low address bits that must be zero for each size.
    generate
        for (genvar b = 0; b < LOW_BITS; b++) begin : g_mask
            assign size_mask[b] = (b < int'(size_log2));
        end
    endgenerate

    always_comb begin
        word_class = (cls == CLS_FP) || (cls == CLS_MULTI) ||
                     (cls == CLS_RSV) || (cls == CLS_COND);
        cond.is_multi = (cls == CLS_MULTI);
        cond.le_multi = le && (cls == CLS_MULTI);
        cond.page     = (cls == CLS_BZERO) && xlate && (wt || ci);
        cond.word     = word_class && (ea_low[1:0] != 2'b00);
        cond.le_mis   = le && ((ea_low & size_mask) != '0);
    end
endmodule

// File: rtl/align_prioritize.sv
module align_prioritize
    import align_pkg::*;
(
    input  cond_t  cond,
    output logic   fault,
    output cause_e cause
);
    always_comb begin
        if (cond.le_multi)    cause = CAUSE_LE_MULTI;
        else if (cond.page)   cause = CAUSE_PAGE;
        else if (cond.word)   cause = CAUSE_WORD;
        else if (cond.le_mis) cause = CAUSE_LE_MIS;
        else                  cause = CAUSE_NONE;
        fault = (cause != CAUSE_NONE);
    end
endmodule

// File: rtl/align_addr_capture.sv
module align_addr_capture #(
    parameter int ADDR_W = 32,
    parameter int ADJUST = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              bump,
    input  logic [ADDR_W-1:0] ea,
    output logic [ADDR_W-1:0] addr_q
);
    localparam logic [ADDR_W-1:0] ADJ_V = ADDR_W'(ADJUST);

    always_ff @(posedge clk) begin
        if (rst)       addr_q <= '0;
        else if (load) addr_q <= bump ? (ea + ADJ_V) : ea;
    end

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(addr_q));
endmodule

// File: rtl/align_exc_detector.sv
module align_exc_detector
    import align_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LOW_BITS = 3,
    parameter int MULT_ADJ = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [2:0]        acc_class,
    input  logic [1:0]        acc_size,
    input  logic [ADDR_W-1:0] acc_ea,
    input  logic              pg_wt,
    input  logic              pg_ci,
    input  logic              xlate_on,
    input  logic              le_mode,
    output logic              exc_req,
    output logic [2:0]        exc_cause,
    output logic [ADDR_W-1:0] fault_addr
);
    typedef enum logic {S_CLEAR = 1'b0, S_TRAP = 1'b1} state_e;

    state_e state_q, state_d;
    cond_t  cond;
    cause_e cause_d, cause_q;
    logic   fault_d;
    logic   take;

    align_classify #(.LOW_BITS(LOW_BITS)) u_classify (
        .cls(acc_class), .size_log2(acc_size), .ea_low(acc_ea[LOW_BITS-1:0]),
        .wt(pg_wt), .ci(pg_ci), .xlate(xlate_on), .le(le_mode), .cond(cond)
    );

    align_prioritize u_prio (.cond(cond), .fault(fault_d), .cause(cause_d));

    assign take = acc_valid && fault_d;

    align_addr_capture #(.ADDR_W(ADDR_W), .ADJUST(MULT_ADJ)) u_capture (
        .clk(clk), .rst(rst), .load(take), .bump(cond.is_multi),
        .ea(acc_ea), .addr_q(fault_addr)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_CLEAR: if (take)  state_d = S_TRAP;
            S_TRAP:  if (!take) state_d = S_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_CLEAR;
            cause_q <= CAUSE_NONE;
        end else begin
            state_q <= state_d;
            cause_q <= take ? cause_d : CAUSE_NONE;
        end
    end

    always_comb begin
        exc_req   = (state_q == S_TRAP);
        exc_cause = cause_q;
    end

    // R9
    req_after_valid_chk: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> $past(acc_valid));
    // R9
    cause_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !exc_req |-> (exc_cause == 3'd0));
    // R5
    le_multi_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && le_mode && acc_class == 3'd3) |=> (exc_req && exc_cause == 3'd1));
    // R2
    bzero_page_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_class == 3'd2 && xlate_on && (pg_wt || pg_ci))
        |=> (exc_req && exc_cause == 3'd2));
    // R7
    multi_bump_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && le_mode && acc_class == 3'd3)
        |=> (fault_addr == $past(acc_ea) + ADDR_W'(MULT_ADJ)));
endmodule

// File: tb/tb_align_exc_detector.sv
module tb_align_exc_detector;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          acc_valid;
    logic [2:0]    acc_class;
    logic [1:0]    acc_size;
    logic [AW-1:0] acc_ea;
    logic          pg_wt, pg_ci, xlate_on, le_mode;
    logic          exc_req;
    logic [2:0]    exc_cause;
    logic [AW-1:0] fault_addr;

    int tests = 0;
    int fails = 0;
    logic [AW-1:0] exp_far;

    always #10 clk = ~clk;

    align_exc_detector #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_class(acc_class),
        .acc_size(acc_size), .acc_ea(acc_ea), .pg_wt(pg_wt), .pg_ci(pg_ci),
        .xlate_on(xlate_on), .le_mode(le_mode), .exc_req(exc_req),
        .exc_cause(exc_cause), .fault_addr(fault_addr)
    );

    function automatic logic [2:0] model_cause(input logic [2:0] c, input logic [1:0] s,
        input logic [2:0] lo, input logic le, input logic xl, input logic wt, input logic ci);
        logic wc;
        logic [2:0] m;
        wc = (c == 3'd1) || (c == 3'd3) || (c == 3'd4) || (c == 3'd5);
        m  = 3'((1 << s) - 1);
        if (le && c == 3'd3)                return 3'd1;
        if (c == 3'd2 && xl && (wt || ci))  return 3'd2;
        if (wc && lo[1:0] != 2'b00)         return 3'd3;
        if (le && (lo & m) != 3'd0)         return 3'd4;
        return 3'd0;
    endfunction

    task automatic check(input string req, input logic [2:0] c,
                         input logic [AW-1:0] f, input logic r);
        tests++;
        if (exc_req !== r || exc_cause !== c || fault_addr !== f) begin
            fails++;
            $display("FAIL %s: req=%0b cause=%0d addr=%h expected req=%0b cause=%0d addr=%h",
                     req, exc_req, exc_cause, fault_addr, r, c, f);
        end
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; acc_valid = 1'b0; acc_class = '0; acc_size = '0; acc_ea = '0;
        pg_wt = 0; pg_ci = 0; xlate_on = 0; le_mode = 0;
        exp_far = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10", 3'd0, '0, 1'b0);   // R10 reset state
        for (int it = 0; it < 3072; it++) begin
            logic [2:0] c;
            logic [1:0] s;
            logic [2:0] lo;
            logic [3:0] md;
            logic [AW-1:0] base;
            logic [2:0] ec;
            string rq;
            c    = 3'(it % 6);
            s    = 2'((it / 6) % 4);
            lo   = 3'((it / 24) % 8);
            md   = 4'((it / 192) % 16);
            base = (it % 3 == 0) ? 32'hFFFF_FFF8 : (32'h1234_5670 + AW'(it) * 8);
            acc_valid = 1'b1; acc_class = c; acc_size = s; acc_ea = base | AW'(lo);
            le_mode = md[0]; xlate_on = md[1]; pg_wt = md[2]; pg_ci = md[3];
            ec = model_cause(c, s, lo, md[0], md[1], md[2], md[3]);
            if (ec != 3'd0) exp_far = (c == 3'd3) ? acc_ea + 32'd4 : acc_ea;
            case (ec)
                3'd1: rq = "R5/R6/R7";
                3'd2: rq = "R2/R6";
                3'd3: rq = (c == 3'd1) ? "R1/R6/R7" : "R3/R6/R7";
                3'd4: rq = "R4/R6/R7";
                default: rq = "R4/R8/R9 no trap";
            endcase
            @(negedge clk);
            check(rq, ec, exp_far, ec != 3'd0);
            acc_valid = 1'b0;
            // idle with a tempting input: capture must hold (R8), no request (R9)
            acc_class = 3'd3; le_mode = 1'b1; acc_ea = 32'hDEAD_BEE1;
            @(negedge clk);
            check("R8/R9 idle", 3'd0, exp_far, 1'b0);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule